// File: doc/BRIEF.md
# Dual-Mode Parallel Interleaver Address Generator

This block generates permuted memory addresses for a parallel turbo decoder built from `LANES` soft-in soft-out processors. It supports two permutation families. The first is an almost-regular permutation for double-binary codes. The second is a quadratic polynomial permutation for single-binary codes. The block length is `N = LANES * W`, where `W` is the window length. Lane `k` owns the index window that starts at `k*W`. Each address is delivered in split form: a bank number `floor(addr / W)` and a local offset `addr mod W`. For legal parameter sets, the local offset is the same on every lane, so only one local bus is emitted per stream and a single address decoder can drive all the banks.

A `start` pulse latches the mode, `W` and six permutation constants. Each constant must be smaller than `N`. `W` must be a multiple of 4 in permutation mode A and even in mode Q, and at least 2. The controller then moves through five states:

- **IDLE**: waits for `start`.
- **CONVERT**: takes `LANES` cycles. It splits each constant into bank and offset form by repeated subtraction of `W`.
- **PREP**: takes one cycle. It derives the step constants and seeds a walker.
- **SEED**: the walker steps through indices 0 to `(LANES-1)*W+1` and loads each lane's starting state as it passes that lane's window start.
- **RUN**: emits one address vector per cycle.

The transitions are IDLE→CONVERT on `start`, CONVERT→PREP when the conversion count ends, PREP→SEED unconditionally, SEED→RUN after the last lane's odd seed, and RUN→IDLE on the last step. In mode Q each lane emits an even and an odd address per step (radix-4 operation), so 2·`LANES` addresses leave the block per cycle. In mode A the count is `LANES`.

Top module: `ilv_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `out_valid`, `out_odd_valid` and `out_last` are 0.
- R2: With `mode_qpp`=0, at step t lane k emits the address of index i=k*W+t, which is (P0·i + 1 + c) mod N. The addend c depends on i mod 4: 0 gives c=0, 1 gives c=P1, 2 gives c=N/2+P2, and 3 gives c=N/2+P3.
- R3: With `mode_qpp`=1, at step t lane k emits the even address for index i=k*W+2t and the odd address for index i+1. Each is (F1·i + F2·i²) mod N.
- R4: Lane k's bank number appears on bits [k*BW +: BW] of `out_bank_e` / `out_bank_o` and equals addr / W. `out_loc_e` / `out_loc_o` carry addr mod W, and that value is common to all lanes.
- R5: After the clock edge that samples `start` in IDLE, `out_valid` first rises exactly LANES+3+(LANES-1)·W edges later.
- R6: `out_valid` stays high for W consecutive cycles in mode A and W/2 in mode Q. `out_last` is high on the final one only, after which `out_valid` and `busy` return to 0.
- R7: `out_odd_valid` is high with `out_valid` in mode Q and stays 0 in mode A.
- R8: A `start` pulse while `busy` is high is ignored: the running address sequence and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new address run (taken only in IDLE) |
| mode_qpp | input | 1 | 0 = almost-regular permutation, 1 = quadratic permutation |
| win_len | input | AW | Window length W |
| prm_p0 | input | BW+AW | Linear step P0 (mode A) |
| prm_p1 | input | BW+AW | Offset for index phase 1 (mode A) |
| prm_p2 | input | BW+AW | Offset for index phase 2 (mode A) |
| prm_p3 | input | BW+AW | Offset for index phase 3 (mode A) |
| prm_f1 | input | BW+AW | Linear coefficient F1 (mode Q) |
| prm_f2 | input | BW+AW | Quadratic coefficient F2 (mode Q) |
| busy | output | 1 | High outside IDLE |
| out_valid | output | 1 | Even/primary address vector valid |
| out_odd_valid | output | 1 | Odd address vector valid (mode Q) |
| out_last | output | 1 | Final step of the run |
| out_loc_e | output | AW | Shared local offset, even/primary stream |
| out_bank_e | output | LANES*BW | Per-lane bank numbers, even/primary stream |
| out_loc_o | output | AW | Shared local offset, odd stream |
| out_bank_o | output | LANES*BW | Per-lane bank numbers, odd stream |

## Verification
The bench samples on the falling clock edge. It counts LANES+3+(LANES-1)·W rising edges from the edge that takes `start`. It expects `out_valid` low one cycle before that point and high at it. From that cycle on, one address vector is due per cycle. The bench compares every lane's bank and the shared offset against its own modular arithmetic at each successive falling edge, for W or W/2 steps. One cycle after `out_last`, it confirms that both `out_valid` and `busy` have dropped. A `start` pulse injected mid-run must leave that same per-cycle schedule intact.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_PREP,
        ST_SEED,
        ST_RUN
    } ilv_state_e;
endpackage

// File: rtl/ilv_addmod.sv
module ilv_addmod #(
    parameter int AW    = 6,
    parameter int BW    = 3,
    parameter int LANES = 8
) (
    input  logic [BW+AW-1:0] a,
    input  logic [BW+AW-1:0] b,
    input  logic [AW-1:0]    win,
    output logic [BW+AW-1:0] y
);
    localparam int PW = BW + AW;
    localparam logic [BW:0] LN = (BW + 1)'(LANES);

    logic [AW:0] lsum;
    logic        wrap;
    logic [BW:0] bsum;

    always_comb begin
        lsum = {1'b0, a[AW-1:0]} + {1'b0, b[AW-1:0]};
        wrap = (lsum >= {1'b0, win});
        bsum = {1'b0, a[PW-1:AW]} + {1'b0, b[PW-1:AW]} + {{BW{1'b0}}, wrap};
        y[AW-1:0]  = wrap ? AW'(lsum - {1'b0, win}) : AW'(lsum);
        y[PW-1:AW] = (bsum >= LN) ? BW'(bsum - LN) : BW'(bsum);
    end
endmodule

// File: rtl/ilv_split.sv
module ilv_split #(
    parameter int AW = 6,
    parameter int BW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [BW+AW-1:0] raw,
    input  logic [AW-1:0]    win,
    output logic [BW+AW-1:0] pair
);
    localparam int PW = BW + AW;

    logic [PW-1:0] rem;
    logic [BW-1:0] quo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
        end else if (load) begin
            rem <= raw;
            quo <= '0;
        end else if (step && (rem >= PW'(win))) begin
            rem <= rem - PW'(win);
            quo <= quo + 1'b1;
        end
    end

    assign pair = {quo, AW'(rem)};
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
    parameter int AW    = 6,
    parameter int BW    = 3,
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_e,
    input  logic               cap_o,
    input  logic               adv,
    input  logic               qpp,
    input  logic [AW-1:0]      win,
    input  logic [BW+AW-1:0]   seed_acc,
    input  logic [BW+AW-1:0]   seed_g,
    input  logic [1:0]         seed_ph,
    input  logic [BW+AW-1:0]   lin_step,
    input  logic [BW+AW-1:0]   g_step,
    input  logic [4*(BW+AW)-1:0] offs,
    output logic [BW+AW-1:0]   addr_e,
    output logic [BW+AW-1:0]   addr_o
);
    localparam int PW = BW + AW;

    logic [PW-1:0] acc_e, g_e, acc_o, g_o;
    logic [1:0]    ph;
    logic [PW-1:0] inc_e, nxt_acc_e, nxt_g_e, nxt_acc_o, nxt_g_o, arp_addr;

    assign inc_e = qpp ? g_e : lin_step;

    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_ae (.a(acc_e), .b(inc_e),  .win(win), .y(nxt_acc_e));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_ge (.a(g_e),   .b(g_step), .win(win), .y(nxt_g_e));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_ao (.a(acc_o), .b(g_o),    .win(win), .y(nxt_acc_o));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_go (.a(g_o),   .b(g_step), .win(win), .y(nxt_g_o));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_of (.a(acc_e), .b(offs[ph*PW +: PW]), .win(win), .y(arp_addr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_e <= '0;
            g_e   <= '0;
            acc_o <= '0;
            g_o   <= '0;
            ph    <= '0;
        end else begin
            if (cap_e) begin
                acc_e <= seed_acc;
                g_e   <= seed_g;
                ph    <= seed_ph;
            end else if (adv) begin
                acc_e <= nxt_acc_e;
                g_e   <= nxt_g_e;
                ph    <= ph + 2'd1;
            end
            if (cap_o) begin
                acc_o <= seed_acc;
                g_o   <= seed_g;
            end else if (adv) begin
                acc_o <= nxt_acc_o;
                g_o   <= nxt_g_o;
            end
        end
    end

    assign addr_e = qpp ? acc_e : arp_addr;
    assign addr_o = acc_o;
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
    import ilv_pkg::*;
#(
    parameter int LANES = 8,
    parameter int AW    = 6,
    parameter int BW    = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_qpp,
    input  logic [AW-1:0]       win_len,
    input  logic [BW+AW-1:0]    prm_p0,
    input  logic [BW+AW-1:0]    prm_p1,
    input  logic [BW+AW-1:0]    prm_p2,
    input  logic [BW+AW-1:0]    prm_p3,
    input  logic [BW+AW-1:0]    prm_f1,
    input  logic [BW+AW-1:0]    prm_f2,
    output logic                busy,
    output logic                out_valid,
    output logic                out_odd_valid,
    output logic                out_last,
    output logic [AW-1:0]       out_loc_e,
    output logic [LANES*BW-1:0] out_bank_e,
    output logic [AW-1:0]       out_loc_o,
    output logic [LANES*BW-1:0] out_bank_o
);
    localparam int PW    = BW + AW;
    localparam int NPRM  = 6;
    localparam int CW    = BW + 1;
    localparam logic [PW-1:0] HALF = {BW'(LANES / 2), AW'(0)};

    ilv_state_e state, state_nxt;

    logic          mode_q;
    logic [AW-1:0] win_q;
    logic [CW-1:0] conv_cnt;
    logic [PW-1:0] w_pi, w_d;
    logic [1:0]    w_ph;
    logic [AW-1:0] w_cnt;
    logic [BW-1:0] w_ptr;
    logic [AW-1:0] step_t, last_t;
    logic [PW-1:0] k_2f2, k_8f2;
    logic [4*PW-1:0] k_offs;

    logic          take;
    logic [PW-1:0] prm_raw [NPRM];
    logic [PW-1:0] prm_pr  [NPRM];
    logic [PW-1:0] c_2f2, c_4f2, c_8f2, c_d0, c_o2, c_o3;
    logic [PW-1:0] w_inc, w_pi_nxt, w_d_nxt, w_2d, seed_g;
    logic          seed_done;
    logic [LANES*PW-1:0] lane_e_all, lane_o_all;

    assign take = (state == ST_IDLE) && start;

    assign prm_raw[0] = prm_p0;
    assign prm_raw[1] = prm_p1;
    assign prm_raw[2] = prm_p2;
    assign prm_raw[3] = prm_p3;
    assign prm_raw[4] = prm_f1;
    assign prm_raw[5] = prm_f2;

    for (genvar p = 0; p < NPRM; p++) begin : g_split
        ilv_split #(.AW(AW), .BW(BW)) u_split (
            .clk(clk), .rst_n(rst_n), .load(take),
            .step(state == ST_CONVERT), .raw(prm_raw[p]),
            .win(win_q), .pair(prm_pr[p])
        );
    end

    // step constants derived once the parameters are split
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_c2 (.a(prm_pr[5]), .b(prm_pr[5]), .win(win_q), .y(c_2f2));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_c4 (.a(c_2f2),     .b(c_2f2),     .win(win_q), .y(c_4f2));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_c8 (.a(c_4f2),     .b(c_4f2),     .win(win_q), .y(c_8f2));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_cd (.a(prm_pr[4]), .b(prm_pr[5]), .win(win_q), .y(c_d0));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_o2 (.a(HALF),      .b(prm_pr[2]), .win(win_q), .y(c_o2));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_o3 (.a(HALF),      .b(prm_pr[3]), .win(win_q), .y(c_o3));

    // sequential walker used only while seeding the lanes
    assign w_inc = mode_q ? w_d : prm_pr[0];
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_wp (.a(w_pi), .b(w_inc), .win(win_q), .y(w_pi_nxt));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_wd (.a(w_d),  .b(k_2f2), .win(win_q), .y(w_d_nxt));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_w2 (.a(w_d),  .b(w_d),   .win(win_q), .y(w_2d));
    ilv_addmod #(.AW(AW), .BW(BW), .LANES(LANES)) u_sg (.a(w_2d), .b(k_2f2), .win(win_q), .y(seed_g));

    assign seed_done = (w_ptr == BW'(LANES - 1)) && (w_cnt == AW'(1));
    assign last_t    = mode_q ? AW'((win_q >> 1) - AW'(1)) : AW'(win_q - AW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (start) state_nxt = ST_CONVERT;
            ST_CONVERT: if (conv_cnt == CW'(LANES - 1)) state_nxt = ST_PREP;
            ST_PREP:    state_nxt = ST_SEED;
            ST_SEED:    if (seed_done) state_nxt = ST_RUN;
            ST_RUN:     if (step_t == last_t) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            win_q    <= AW'(2);
            conv_cnt <= '0;
            w_pi     <= '0;
            w_d      <= '0;
            w_ph     <= '0;
            w_cnt    <= '0;
            w_ptr    <= '0;
            step_t   <= '0;
            k_2f2    <= '0;
            k_8f2    <= '0;
            k_offs   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    mode_q   <= mode_qpp;
                    win_q    <= win_len;
                    conv_cnt <= '0;
                end
                ST_CONVERT: conv_cnt <= conv_cnt + CW'(1);
                ST_PREP: begin
                    k_2f2  <= c_2f2;
                    k_8f2  <= c_8f2;
                    k_offs <= {c_o3, c_o2, prm_pr[1], PW'(0)};
                    w_pi   <= mode_q ? PW'(0) : PW'(1);
                    w_d    <= c_d0;
                    w_ph   <= '0;
                    w_cnt  <= '0;
                    w_ptr  <= '0;
                end
                ST_SEED: begin
                    w_pi <= w_pi_nxt;
                    w_d  <= w_d_nxt;
                    w_ph <= w_ph + 2'd1;
                    if (w_cnt == win_q - AW'(1)) begin
                        w_cnt <= '0;
                        w_ptr <= w_ptr + BW'(1);
                    end else begin
                        w_cnt <= w_cnt + AW'(1);
                    end
                    step_t <= '0;
                end
                ST_RUN: step_t <= step_t + AW'(1);
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PW-1:0] ae, ao;
        ilv_lane #(.AW(AW), .BW(BW), .LANES(LANES)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .cap_e((state == ST_SEED) && (w_ptr == BW'(k)) && (w_cnt == AW'(0))),
            .cap_o((state == ST_SEED) && (w_ptr == BW'(k)) && (w_cnt == AW'(1))),
            .adv(state == ST_RUN), .qpp(mode_q), .win(win_q),
            .seed_acc(w_pi), .seed_g(seed_g), .seed_ph(w_ph),
            .lin_step(prm_pr[0]), .g_step(k_8f2), .offs(k_offs),
            .addr_e(ae), .addr_o(ao)
        );
        assign lane_e_all[k*PW +: PW] = ae;
        assign lane_o_all[k*PW +: PW] = ao;
        assign out_bank_e[k*BW +: BW] = ae[PW-1:AW];
        assign out_bank_o[k*BW +: BW] = ao[PW-1:AW];
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        out_valid     = (state == ST_RUN);
        out_odd_valid = (state == ST_RUN) && mode_q;
        out_last      = (state == ST_RUN) && (step_t == last_t);
        out_loc_e     = lane_e_all[AW-1:0];
        out_loc_o     = lane_o_all[AW-1:0];
    end
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
    parameter int LANES = 8,
    parameter int AW    = 6,
    parameter int BW    = $clog2(LANES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  out_valid,
    input logic                  out_odd_valid,
    input logic                  out_last,
    input logic                  mode_q,
    input logic [LANES*(BW+AW)-1:0] lane_e_all,
    input logic [LANES*(BW+AW)-1:0] lane_o_all
);
    localparam int PW = BW + AW;

    logic loc_same_e, loc_same_o, bank_ok;

    always_comb begin
        loc_same_e = 1'b1;
        loc_same_o = 1'b1;
        bank_ok    = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (lane_e_all[k*PW +: AW] != lane_e_all[AW-1:0]) loc_same_e = 1'b0;
            if (lane_o_all[k*PW +: AW] != lane_o_all[AW-1:0]) loc_same_o = 1'b0;
            if (32'(lane_e_all[k*PW+AW +: BW]) >= LANES) bank_ok = 1'b0;
            if (32'(lane_o_all[k*PW+AW +: BW]) >= LANES) bank_ok = 1'b0;
        end
    end

    // R4
    shared_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (loc_same_e && (!out_odd_valid || loc_same_o)));

    // R4
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> bank_ok);

    // R7
    odd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_odd_valid |-> (out_valid && mode_q));

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && !busy));

    // R5
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !out_valid));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);
endmodule

bind ilv_addr_gen ilv_checker #(.LANES(LANES), .AW(AW), .BW(BW)) u_ilv_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .out_valid(out_valid), .out_odd_valid(out_odd_valid), .out_last(out_last),
    .mode_q(mode_q), .lane_e_all(lane_e_all), .lane_o_all(lane_o_all)
);

// File: tb/ilv_addr_gen_bench.sv
module ilv_addr_gen_bench;
    localparam int LANES = 8;
    localparam int AW    = 6;
    localparam int BW    = 3;
    localparam int PW    = BW + AW;
    localparam int NCFG  = 4;

    // stimulus table: mode, W, P0, P1, P2, P3, F1, F2
    localparam int T_MODE [NCFG] = '{0, 0, 1, 1};
    localparam int T_WIN  [NCFG] = '{8, 4, 8, 6};
    localparam int T_P0   [NCFG] = '{13, 7, 0, 0};
    localparam int T_P1   [NCFG] = '{5, 2, 0, 0};
    localparam int T_P2   [NCFG] = '{40, 20, 0, 0};
    localparam int T_P3   [NCFG] = '{3, 31, 0, 0};
    localparam int T_F1   [NCFG] = '{0, 0, 7, 5};
    localparam int T_F2   [NCFG] = '{0, 0, 16, 12};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_qpp = 1'b0;
    logic [AW-1:0] win_len = '0;
    logic [PW-1:0] prm_p0 = '0, prm_p1 = '0, prm_p2 = '0, prm_p3 = '0, prm_f1 = '0, prm_f2 = '0;
    logic busy, out_valid, out_odd_valid, out_last;
    logic [AW-1:0] out_loc_e, out_loc_o;
    logic [LANES*BW-1:0] out_bank_e, out_bank_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;

    ilv_addr_gen #(.LANES(LANES), .AW(AW)) u_ilv_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_qpp(mode_qpp),
        .win_len(win_len), .prm_p0(prm_p0), .prm_p1(prm_p1), .prm_p2(prm_p2),
        .prm_p3(prm_p3), .prm_f1(prm_f1), .prm_f2(prm_f2),
        .busy(busy), .out_valid(out_valid), .out_odd_valid(out_odd_valid),
        .out_last(out_last), .out_loc_e(out_loc_e), .out_bank_e(out_bank_e),
        .out_loc_o(out_loc_o), .out_bank_o(out_bank_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_addr(input int c, input longint i);
        longint n, off;
        n = longint'(LANES) * T_WIN[c];
        if (T_MODE[c] == 1) return (T_F1[c] * i + T_F2[c] * i * i) % n;
        case (i % 4)
            0: off = 0;
            1: off = T_P1[c];
            2: off = n / 2 + T_P2[c];
            default: off = n / 2 + T_P3[c];
        endcase
        return (T_P0[c] * i + 1 + off) % n;
    endfunction

    // runs one table entry; poke_step >= 0 injects a start pulse during RUN
    task automatic run_cfg(input int c, input int poke_step);
        int w, steps, lat;
        longint ie, ae, ao;
        w = T_WIN[c];
        steps = (T_MODE[c] == 1) ? w / 2 : w;
        lat = LANES + 3 + (LANES - 1) * w;
        @(negedge clk);
        mode_qpp = T_MODE[c][0];
        win_len  = AW'(w);
        prm_p0 = PW'(T_P0[c]); prm_p1 = PW'(T_P1[c]); prm_p2 = PW'(T_P2[c]);
        prm_p3 = PW'(T_P3[c]); prm_f1 = PW'(T_F1[c]); prm_f2 = PW'(T_F2[c]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        mode_qpp = ~mode_qpp;   // inputs after start must not matter
        win_len = '0;
        chk($sformatf("R5 busy after start cfg%0d", c), busy, 1);
        repeat (lat - 1) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R5 valid low before latency cfg%0d", c), out_valid, 0);
        @(posedge clk);
        for (int t = 0; t < steps; t++) begin
            @(negedge clk);
            chk($sformatf("R5 R6 valid cfg%0d t%0d", c, t), out_valid, 1);
            chk($sformatf("R7 odd valid cfg%0d t%0d", c, t), out_odd_valid, T_MODE[c]);
            chk($sformatf("R6 last cfg%0d t%0d", c, t), out_last, (t == steps - 1) ? 1 : 0);
            for (int k = 0; k < LANES; k++) begin
                if (T_MODE[c] == 1) begin
                    ie = longint'(k) * w + 2 * t;
                    ae = ref_addr(c, ie);
                    ao = ref_addr(c, ie + 1);
                    chk($sformatf("R3 R4 even bank cfg%0d t%0d lane%0d", c, t, k),
                        out_bank_e[k*BW +: BW], ae / w);
                    chk($sformatf("R3 R4 odd bank cfg%0d t%0d lane%0d", c, t, k),
                        out_bank_o[k*BW +: BW], ao / w);
                    chk($sformatf("R3 R4 even loc cfg%0d t%0d lane%0d", c, t, k), out_loc_e, ae % w);
                    chk($sformatf("R3 R4 odd loc cfg%0d t%0d lane%0d", c, t, k), out_loc_o, ao % w);
                end else begin
                    ie = longint'(k) * w + t;
                    ae = ref_addr(c, ie);
                    chk($sformatf("R2 R4 bank cfg%0d t%0d lane%0d", c, t, k),
                        out_bank_e[k*BW +: BW], ae / w);
                    chk($sformatf("R2 R4 loc cfg%0d t%0d lane%0d", c, t, k), out_loc_e, ae % w);
                end
            end
            if (t == poke_step) begin
                start = 1'b1;   // R8: must be ignored
                @(posedge clk);
                #1 start = 1'b0;
            end else begin
                @(posedge clk);
            end
        end
        @(negedge clk);
        chk($sformatf("R6 valid drops cfg%0d", c), out_valid, 0);
        chk($sformatf("R6 R8 busy drops cfg%0d", c), busy, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 odd valid after reset", out_odd_valid, 0);
        chk("R1 last after reset", out_last, 0);

        // table walk
        for (int c = 0; c < NCFG; c++) run_cfg(c, -1);

        // directed: start pulses during runs are ignored (R8)
        run_cfg(0, 3);
        run_cfg(2, 1);

        // directed: back-to-back runs in opposite modes, smallest legal ARP window
        run_cfg(1, 0);
        run_cfg(3, -1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule